// File: doc/BRIEF.md
# Four-Lane Word-Striped Receive Combiner

This block rebuilds a single word stream from four receive lanes that carry consecutive words in rotation. Each lane writes its already-aligned words, each tagged with a flag marking it as an idle skip word, into a small FIFO of its own. Every cycle a rotating lane pointer takes one word from the FIFO it points at and presents it on one registered output with a valid flag. All four lanes and the combiner share one clock, taken from any one of the lanes. Because that clock samples a whole word from every lane, no pointer-offset deskew stage is needed.

Rate matching works on the four FIFOs as one pool. A central controller compares the total fill of all four FIFOs with a high and a low threshold. It then changes how the pointer steps instead of moving data. To drop a skip word, the pointer jumps over the lane that holds it. To insert a skip word, the pointer dwells on that lane so its word goes out twice. A mode input selects trunked operation. In that mode the lanes carry independent streams, the central controller is idle, and the pointer always moves on by one lane.

Top module: `stripe_rx_combiner`

## Requirements
- R1: A synchronous active-high reset empties every lane FIFO, puts the pointer on lane 0, cancels any pending insert or drop request and drives `out_valid` low on the cycle after the reset edge.
- R2: In striped mode with no rate-matching action, output words come from lanes 0, 1, 2, 3, 0, ... in turn, one lane per output word.
- R3: While the FIFO at the pointer is empty, `out_valid` is 0 and the pointer holds. In a drop cycle this also applies when the lane after the pointer is empty.
- R4: A drop request is set when the total fill of all four FIFOs exceeds `HI_THR`. In striped mode, when a drop is pending and the head word at the pointer has `skip`=1, that word is consumed without being output. In the same cycle the head word of the next lane is output, and the pointer moves on by two lanes.
- R5: An insert request is set when the total fill is below `LO_THR`. In striped mode, when an insert is pending and the head word at the pointer has `skip`=1, that word is output without being consumed. It is output again on the next cycle, and only then does the pointer move on.
- R6: Only words with `skip`=1 are ever dropped or repeated. Every word with `skip`=0 comes out exactly once, and a drop request and an insert request are never pending together. A threshold crossing in the other direction cancels the opposite request.
- R7: In trunked mode (`trunk_mode`=1), the pointer moves on by exactly one lane for each output word. Skip words pass through unchanged whatever the fill, and no central request stays pending.
- R8: The output is registered. A word selected in one cycle appears on `out_data`/`out_skip` with `out_valid`=1 after the next clock edge.
- R9: Each lane FIFO keeps its words in push order, and a push and a pop of the same lane may take place in the same cycle.
- R10: The second issue of a repeated skip word is always a normal issue that consumes the word: no new insert or drop can start on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for all lanes and the combiner |
| rst | input | 1 | Synchronous active-high reset |
| trunk_mode | input | 1 | 1 = independent lane streams, 0 = striped stream with central rate matching |
| lane_push | input | 4 | Per-lane write strobe, bit i for lane i |
| lane_data | input | 4*DATA_W | Lane words, lane i in bits [i*DATA_W +: DATA_W] |
| lane_skip | input | 4 | Per-lane skip flag for the pushed word, 1 = idle skip word |
| out_valid | output | 1 | Combined output word is valid |
| out_data | output | DATA_W | Combined output word |
| out_skip | output | 1 | Skip flag of the combined output word |

## Verification
The assertions take it as given that a lane is never pushed while its FIFO is full. The block has no back-pressure towards the lanes, so an overflow would break the ordering checks. The stimulus in the bench tracks the occupancy of every lane in its reference model and raises a lane's write strobe only when that lane has room before the edge. Fill is steered across the thresholds by changing how often lanes are pushed: sparse pushes keep the pool below the low mark, so inserts happen, and dense pushes drive it past the high mark, so drops happen. Skip words are mixed in at a set rate so that both actions have words to act on.

// File: rtl/stripe_rx_pkg.sv
package stripe_rx_pkg;

    localparam int LANES = 4;

    typedef logic [1:0] lane_idx_t;

    typedef enum logic [1:0] {
        ACT_IDLE   = 2'd0,
        ACT_NORMAL = 2'd1,
        ACT_DROP   = 2'd2,
        ACT_REPEAT = 2'd3
    } issue_act_t;

    function automatic lane_idx_t lane_step(lane_idx_t p, logic [1:0] n);
        return lane_idx_t'(p + n);
    endfunction

endpackage

// File: rtl/lane_fifo.sv
module lane_fifo #(
    parameter int WIDTH = 33,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full,
    output logic [CW-1:0]    count
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [CW-1:0]    wr_ptr, rd_ptr;

    assign count = wr_ptr - rd_ptr;
    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
    assign head  = mem[rd_ptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr[AW-1:0]] <= wdata;
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (pop) rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // R9: the lane source never writes into a full FIFO
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst) push |-> !full);
    // R3: the combiner never reads an empty FIFO
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);

endmodule

// File: rtl/rate_ctrl.sv
module rate_ctrl #(
    parameter int CNT_W  = 6,
    parameter int HI_THR = 20,
    parameter int LO_THR = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trunk_mode,
    input  logic [CNT_W-1:0] fill,
    input  logic             drop_done,
    input  logic             rep_done,
    output logic             drop_pend,
    output logic             rep_pend
);
    logic above, below;

    assign above = (fill > CNT_W'(HI_THR));
    assign below = (fill < CNT_W'(LO_THR));

    always_ff @(posedge clk) begin
        if (rst || trunk_mode) begin
            drop_pend <= 1'b0;
            rep_pend  <= 1'b0;
        end else begin
            if (above)          drop_pend <= 1'b1;
            else if (below)     drop_pend <= 1'b0;
            else if (drop_done) drop_pend <= 1'b0;

            if (below)          rep_pend <= 1'b1;
            else if (above)     rep_pend <= 1'b0;
            else if (rep_done)  rep_pend <= 1'b0;
        end
    end

    // R6: never both requests at once
    p_excl_req_r6: assert property (@(posedge clk) disable iff (rst) !(drop_pend && rep_pend));
    // R7: trunked mode leaves no central request pending
    p_trunk_idle_r7: assert property (@(posedge clk) disable iff (rst)
        trunk_mode |=> !drop_pend && !rep_pend);

endmodule

// File: rtl/lane_select.sv
module lane_select
    import stripe_rx_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int WW    = DATA_W + 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       trunk_mode,
    input  logic [LANES-1:0][WW-1:0]   heads,
    input  logic [LANES-1:0]           empties,
    input  logic                       drop_pend,
    input  logic                       rep_pend,
    output logic [LANES-1:0]           pops,
    output logic                       drop_done,
    output logic                       rep_done,
    output logic                       out_valid,
    output logic [DATA_W-1:0]          out_data,
    output logic                       out_skip
);
    lane_idx_t  ptr, ptr_n, nxt, sel;
    logic       dwell, dwell_n;
    issue_act_t act;
    logic       head_skip;

    assign nxt       = lane_step(ptr, 2'd1);
    assign head_skip = heads[ptr][DATA_W];

    always_comb begin
        act     = ACT_IDLE;
        pops    = '0;
        sel     = ptr;
        ptr_n   = ptr;
        dwell_n = dwell;
        if (!empties[ptr]) begin
            if (!trunk_mode && !dwell && drop_pend && head_skip) begin
                if (!empties[nxt]) begin
                    act        = ACT_DROP;
                    sel        = nxt;
                    pops[ptr]  = 1'b1;
                    pops[nxt]  = 1'b1;
                    ptr_n      = lane_step(ptr, 2'd2);
                end
            end else if (!trunk_mode && !dwell && rep_pend && head_skip) begin
                act     = ACT_REPEAT;
                dwell_n = 1'b1;
            end else begin
                act       = ACT_NORMAL;
                pops[ptr] = 1'b1;
                ptr_n     = nxt;
                dwell_n   = 1'b0;
            end
        end
    end

    assign drop_done = (act == ACT_DROP);
    assign rep_done  = (act == ACT_REPEAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr       <= '0;
            dwell     <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_skip  <= 1'b0;
        end else begin
            ptr       <= ptr_n;
            dwell     <= dwell_n;
            out_valid <= (act != ACT_IDLE);
            out_data  <= heads[sel][DATA_W-1:0];
            out_skip  <= heads[sel][DATA_W];
        end
    end

    // R1: reset leaves the pointer on lane 0 with no output
    p_reset_state_r1: assert property (@(posedge clk) rst |=> !out_valid && ptr == 2'd0);
    // R3: an empty lane at the pointer stalls output and pointer
    p_stall_r3: assert property (@(posedge clk) disable iff (rst)
        empties[ptr] |=> !out_valid && ptr == $past(ptr));
    // R7: trunked issue moves the pointer by exactly one lane
    p_trunk_step_r7: assert property (@(posedge clk) disable iff (rst)
        (trunk_mode && !empties[ptr]) |=> out_valid && ptr == lane_step($past(ptr), 2'd1));
    // R5: a repeat issues a skip word and leaves the pointer in place
    p_repeat_hold_r5: assert property (@(posedge clk) disable iff (rst)
        rep_done |=> out_valid && out_skip && ptr == $past(ptr));
    // R10: a repeat is never followed directly by another repeat or a drop
    p_no_double_r10: assert property (@(posedge clk) disable iff (rst)
        rep_done |=> !rep_done && !drop_done);
    // R4: a drop advances the pointer by two lanes and still issues a word
    p_drop_step_r4: assert property (@(posedge clk) disable iff (rst)
        drop_done |=> out_valid && ptr == lane_step($past(ptr), 2'd2));
    // R6: only skip words are repeated or dropped
    p_skip_only_r6: assert property (@(posedge clk) disable iff (rst)
        (drop_done || rep_done) |-> head_skip);

endmodule

// File: rtl/stripe_rx_combiner.sv
module stripe_rx_combiner
    import stripe_rx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    parameter int HI_THR = 20,
    parameter int LO_THR = 6,
    localparam int WW    = DATA_W + 1,
    localparam int LCW   = $clog2(DEPTH) + 1,
    localparam int CNT_W = $clog2(LANES * DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      trunk_mode,
    input  logic [LANES-1:0]          lane_push,
    input  logic [LANES*DATA_W-1:0]   lane_data,
    input  logic [LANES-1:0]          lane_skip,
    output logic                      out_valid,
    output logic [DATA_W-1:0]         out_data,
    output logic                      out_skip
);
    logic [LANES-1:0][WW-1:0]  heads;
    logic [LANES-1:0]          empties, fulls, pops;
    logic [LANES-1:0][LCW-1:0] counts;
    logic [CNT_W-1:0]          fill;
    logic                      drop_pend, rep_pend, drop_done, rep_done;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        lane_fifo #(.WIDTH(WW), .DEPTH(DEPTH)) u_fifo (
            .clk   (clk),
            .rst   (rst),
            .push  (lane_push[i]),
            .wdata ({lane_skip[i], lane_data[i*DATA_W +: DATA_W]}),
            .pop   (pops[i]),
            .head  (heads[i]),
            .empty (empties[i]),
            .full  (fulls[i]),
            .count (counts[i])
        );
    end

    always_comb begin
        fill = '0;
        for (int i = 0; i < LANES; i++) fill = fill + CNT_W'(counts[i]);
    end

    rate_ctrl #(.CNT_W(CNT_W), .HI_THR(HI_THR), .LO_THR(LO_THR)) u_rate (
        .clk        (clk),
        .rst        (rst),
        .trunk_mode (trunk_mode),
        .fill       (fill),
        .drop_done  (drop_done),
        .rep_done   (rep_done),
        .drop_pend  (drop_pend),
        .rep_pend   (rep_pend)
    );

    lane_select #(.DATA_W(DATA_W)) u_sel (
        .clk        (clk),
        .rst        (rst),
        .trunk_mode (trunk_mode),
        .heads      (heads),
        .empties    (empties),
        .drop_pend  (drop_pend),
        .rep_pend   (rep_pend),
        .pops       (pops),
        .drop_done  (drop_done),
        .rep_done   (rep_done),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_skip   (out_skip)
    );

    // R9: a full lane is never written
    p_full_guard_r9: assert property (@(posedge clk) disable iff (rst)
        (|(lane_push & fulls)) == 1'b0);

endmodule

// File: tb/stripe_rx_combiner_tb.sv
module stripe_rx_combiner_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 32;
    localparam int DEPTH  = 8;
    localparam int HI_THR = 20;
    localparam int LO_THR = 6;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  trunk_mode = 1'b0;
    logic [3:0]            lane_push = '0;
    logic [4*DATA_W-1:0]   lane_data = '0;
    logic [3:0]            lane_skip = '0;
    logic                  out_valid;
    logic [DATA_W-1:0]     out_data;
    logic                  out_skip;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    stripe_rx_combiner #(.DATA_W(DATA_W), .DEPTH(DEPTH), .HI_THR(HI_THR), .LO_THR(LO_THR)) u_dut (
        .clk(clk), .rst(rst), .trunk_mode(trunk_mode),
        .lane_push(lane_push), .lane_data(lane_data), .lane_skip(lane_skip),
        .out_valid(out_valid), .out_data(out_data), .out_skip(out_skip)
    );

    // reference model: queues per lane, word = {skip, data}
    logic [DATA_W:0] mq0[$], mq1[$], mq2[$], mq3[$];
    int  m_ptr = 0;
    bit  m_drop = 0, m_rep = 0, m_dwell = 0;
    bit  e_valid = 0;
    logic [DATA_W:0] e_word = '0;
    int  n_drops = 0, n_reps = 0;

    function automatic int qsize(int l);
        case (l)
            0: return mq0.size();
            1: return mq1.size();
            2: return mq2.size();
            default: return mq3.size();
        endcase
    endfunction

    function automatic logic [DATA_W:0] qhead(int l);
        case (l)
            0: return mq0[0];
            1: return mq1[0];
            2: return mq2[0];
            default: return mq3[0];
        endcase
    endfunction

    task automatic qpop(int l);
        case (l)
            0: void'(mq0.pop_front());
            1: void'(mq1.pop_front());
            2: void'(mq2.pop_front());
            default: void'(mq3.pop_front());
        endcase
    endtask

    task automatic qpush(int l, logic [DATA_W:0] w);
        case (l)
            0: mq0.push_back(w);
            1: mq1.push_back(w);
            2: mq2.push_back(w);
            default: mq3.push_back(w);
        endcase
    endtask

    always @(posedge clk) begin
        if (rst) begin
            mq0.delete(); mq1.delete(); mq2.delete(); mq3.delete();
            m_ptr = 0; m_drop = 0; m_rep = 0; m_dwell = 0; e_valid = 0;
        end else begin
            int fill;
            int nx;
            bit dd, rd;
            fill = qsize(0) + qsize(1) + qsize(2) + qsize(3);
            nx = (m_ptr + 1) % 4;
            dd = 0; rd = 0; e_valid = 0;
            if (qsize(m_ptr) > 0) begin
                logic [DATA_W:0] h;
                h = qhead(m_ptr);
                if (!trunk_mode && !m_dwell && m_drop && h[DATA_W]) begin
                    if (qsize(nx) > 0) begin
                        e_valid = 1; e_word = qhead(nx);
                        qpop(m_ptr); qpop(nx);
                        m_ptr = (m_ptr + 2) % 4; dd = 1; n_drops++;
                    end
                end else if (!trunk_mode && !m_dwell && m_rep && h[DATA_W]) begin
                    e_valid = 1; e_word = h; m_dwell = 1; rd = 1; n_reps++;
                end else begin
                    e_valid = 1; e_word = h; qpop(m_ptr);
                    m_ptr = nx; m_dwell = 0;
                end
            end
            for (int l = 0; l < 4; l++)
                if (lane_push[l]) qpush(l, {lane_skip[l], lane_data[l*DATA_W +: DATA_W]});
            if (trunk_mode) begin
                m_drop = 0; m_rep = 0;
            end else begin
                if (fill > HI_THR) m_drop = 1;
                else if (fill < LO_THR) m_drop = 0;
                else if (dd) m_drop = 0;
                if (fill < LO_THR) m_rep = 1;
                else if (fill > HI_THR) m_rep = 0;
                else if (rd) m_rep = 0;
            end
        end
    end

    task automatic check_out();
        checks++;
        if (out_valid !== e_valid) begin
            failures++;
            $display("FAIL %s out_valid actual=%0b expected=%0b t=%0t", cur_req, out_valid, e_valid, $time);
        end else if (e_valid && ({out_skip, out_data} !== e_word)) begin
            failures++;
            $display("FAIL %s word actual=%h expected=%h t=%0t", cur_req, {out_skip, out_data}, e_word, $time);
        end
    endtask

    int seq = 0;

    task automatic drive(int push_pct, int skip_pct);
        for (int l = 0; l < 4; l++) begin
            bit p;
            p = (($urandom % 100) < push_pct) && (qsize(l) < DEPTH);
            lane_push[l] = p;
            lane_skip[l] = (($urandom % 100) < skip_pct);
            lane_data[l*DATA_W +: DATA_W] = DATA_W'(seq);
            seq++;
        end
    endtask

    task automatic run(int cycles, int push_pct, int skip_pct);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            check_out();
            drive(push_pct, skip_pct);
        end
    endtask

    task automatic named_check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        int d0, r0;
        repeat (3) @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        check_out();
        named_check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
        rst = 1'b0;

        // R2: fixed rotation, lane 0 word first; exact lane order checked
        cur_req = "R2";
        @(negedge clk);
        check_out();
        lane_push = 4'hF; lane_skip = '0;
        for (int l = 0; l < 4; l++) lane_data[l*DATA_W +: DATA_W] = DATA_W'(32'hA0 + l);
        @(negedge clk);
        check_out();
        lane_push = '0;
        for (int l = 0; l < 4; l++) begin
            @(negedge clk);
            check_out();
            named_check(out_valid && out_data == DATA_W'(32'hA0 + l), "R2 lane order", int'(out_data), 32'hA0 + l);
        end

        // R3 R9: sparse data words, stalls and per-lane ordering
        cur_req = "R3 R9";
        run(300, 30, 0);
        // R5 R10: low fill with skip words forces repeats
        cur_req = "R5 R10";
        r0 = n_reps;
        run(400, 25, 35);
        named_check(n_reps > r0, "R5 repeats occurred", n_reps - r0, 1);
        // R4 R6: dense pushes push fill above the high mark
        cur_req = "R4 R6";
        d0 = n_drops;
        run(500, 95, 25);
        named_check(n_drops > d0, "R4 drops occurred", n_drops - d0, 1);
        // R7: trunked mode, no central action even at high fill
        cur_req = "R7";
        trunk_mode = 1'b1;
        d0 = n_drops; r0 = n_reps;
        run(300, 95, 40);
        run(200, 20, 40);
        named_check(n_drops == d0 && n_reps == r0, "R7 no central action", n_drops - d0 + n_reps - r0, 0);
        // R1: reset in the middle of traffic
        cur_req = "R1";
        trunk_mode = 1'b0;
        run(100, 95, 20);
        rst = 1'b1; lane_push = '0;
        @(negedge clk);
        check_out();
        named_check(out_valid == 1'b0, "R1 mid-run reset", out_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        check_out();
        named_check(out_valid == 1'b0, "R1 fifos emptied", out_valid, 0);
        // R8 R6: mixed traffic across both marks after reset
        cur_req = "R8 R6";
        run(400, 60, 30);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule